// File: doc/BRIEF.md
# XON/XOFF Software Flow Control Engine

This block performs character-based flow control for one serial channel. It sits between a receiver that delivers decoded characters, a transmit FIFO, and a transmit shifter. The FIFO and the shifter appear as simple handshake ports. Every received character is compared with two programmable patterns, one for XON and one for XOFF. A match sets a sticky detection flag, whether or not any automatic mode is on, so the comparison can also serve as a general character detector.

When automatic transmit flow is on, a received XOFF stops the flow of FIFO data into the shifter and a received XON restarts it. A character that is already being shifted always finishes. When automatic receive flow is on, a command pulse queues an XON or XOFF character. That character goes into the shifter ahead of any FIFO data, and it goes even while FIFO data is halted.

An 8-bit status word reports four things: which flow characters were seen, which were sent, the transmit flow state, and the transmit character state. Reading it clears the upper half. A separate control word turns recognition features on and off through enable/disable bit pairs, and the disable bit of a pair wins.

Top module: `xonxoff_flow_engine`

## Requirements
- R1: `stat_q[7:6]` holds sticky received-character flags. Bit 6 is set when a received character equals `cfg_xoff_char`, and bit 7 when it equals `cfg_xon_char`, so 01 means XOFF seen, 10 XON seen and 11 both. A flag shows one cycle after the match, whatever the auto-mode and control-word settings.
- R2: A `stat_rd` pulse clears `stat_q[7:4]` as seen in the next cycle. A match or an inserted character in the same cycle as the read is kept, because its flag is applied after the clear.
- R3: On `ctl_wr`, for each pair k, `ctl_wdata[2k+1]` clears `ctl_en[k]` and `ctl_wdata[2k]` sets it. Writing 0 leaves the bit unchanged, and writing 1 to both bits of a pair leaves the feature disabled. Pair 0 is XOFF recognition, 1 is XON recognition, 2 is address recognition and 3 is the watchdog. All are 0 after reset.
- R4: `recog_evt[0]` pulses one cycle after an XOFF match and `recog_evt[1]` one cycle after an XON match, but only while the matching control bit (`ctl_en[0]` or `ctl_en[1]`) is set.
- R5: With `cfg_tx_auto` set, `stat_q[3:2]` follows the transmit flow. It is 00 while running. An XOFF that arrives while a character is in the shifter gives 01 (halt pending), which becomes 11 (halted) in the cycle after the shifter goes idle. An XOFF that arrives while the shifter is idle gives 11 directly.
- R6: While the state is 01 or 11, no FIFO data is popped. An XON gives 10 (re-enabled), and data then flows again. A status read returns 10 to 00.
- R7: With `cfg_tx_auto` clear, `stat_q[3:2]` stays 00 and received flow characters never stop FIFO data.
- R8: With `cfg_rx_auto` set, a `cmd_send_xoff` or `cmd_send_xon` pulse makes `stat_q[1:0]` read 10 or 11 respectively. The character is loaded at the first cycle the shifter is idle, before any FIFO data and regardless of the halt state. It never interrupts a character being shifted, and inserting it does not change `stat_q[3:2]`.
- R9: `stat_q[5:4]` records the inserted characters: 01 means XON sent, 10 XOFF sent and 11 both. It reads 00 while `cfg_rx_auto` is clear and resets to 00 when that bit is cleared. Commands given while `cfg_rx_auto` is clear are ignored.
- R10: After an inserted character is loaded, `stat_q[1:0]` reads 01 (waiting for data). It stays 01 while the shifter is busy or the FIFO is empty, and returns to 00 once FIFO data is present with the shifter idle. It is forced to 00 while both auto modes are clear.
- R11: After reset the status word is 0, no load or pop is requested and no recognition event is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_xon_char | input | W | XON pattern |
| cfg_xoff_char | input | W | XOFF pattern |
| cfg_tx_auto | input | 1 | Received XON/XOFF control the transmitter |
| cfg_rx_auto | input | 1 | Flow character insertion mode enable |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 2*N_PAIRS | Control write data, enable/disable pairs |
| ctl_en | output | N_PAIRS | Resulting feature enables |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | W | Received character |
| recog_evt | output | 2 | Recognition pulses {XON, XOFF} |
| cmd_send_xon | input | 1 | Queue an XON insertion |
| cmd_send_xoff | input | 1 | Queue an XOFF insertion |
| fifo_valid | input | 1 | Transmit FIFO holds data |
| fifo_data | input | W | Head of transmit FIFO |
| fifo_pop | output | 1 | Take the FIFO head |
| sh_busy | input | 1 | Shifter is sending a character |
| sh_load | output | 1 | Load `sh_data` into the shifter |
| sh_data | output | W | Character to load |
| stat_rd | input | 1 | Status read strobe |
| stat_q | output | 8 | Status word |

## Verification
The bench builds the block with its defaults: 8-bit characters, four control pairs and insertion present. The bench's shifter model holds each character for six cycles, so halt-pending, insertion behind a busy shifter and drain to idle all happen within a few dozen cycles. The FIFO model numbers its entries in sequence, so the order of data and inserted characters can be read directly from the load log. A random phase with both auto modes off exercises detection flags, read clears, control pairs and ignored commands. Directed sequences then cover the halt, resume and insertion orderings.

// File: rtl/xf_pkg.sv
`timescale 1ns/1ps
package xf_pkg;
   // transmit flow state, reported in status bits [3:2]
   typedef enum logic [1:0] {
      FL_RUN      = 2'b00,
      FL_STOPPING = 2'b01,
      FL_RESUMED  = 2'b10,
      FL_STOPPED  = 2'b11
   } flow_e;

   // transmit character state, reported in status bits [1:0]
   typedef enum logic [1:0] {
      TC_DATA = 2'b00,
      TC_WAIT = 2'b01,
      TC_XOFF = 2'b10,
      TC_XON  = 2'b11
   } txc_e;
endpackage

// File: rtl/xf_ctl_pairs.sv
`timescale 1ns/1ps
module xf_ctl_pairs #(
   parameter int N_PAIRS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [2*N_PAIRS-1:0]   wdata,
   output logic [N_PAIRS-1:0]     en
);
   for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                en_q <= 1'b0;
         else if (wr) begin
            if (wdata[2*g+1])       en_q <= 1'b0;
            else if (wdata[2*g])    en_q <= 1'b1;
         end
      end
      assign en[g] = en_q;

      // R3
      dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && wdata[2*g+1]) |=> !en[g]);
      // R3
      en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && !wdata[2*g+1] && wdata[2*g]) |=> en[g]);
      // R3
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr || wdata[2*g+1:2*g] == 2'b00) |=> $stable(en[g]));
   end
endmodule

// File: rtl/xf_rx_match.sv
`timescale 1ns/1ps
module xf_rx_match #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_valid,
   input  logic [W-1:0] rx_data,
   input  logic [W-1:0] xon_char,
   input  logic [W-1:0] xoff_char,
   input  logic         stat_rd,
   input  logic [1:0]   recog_en,   // {xon, xoff}
   output logic         hit_xon,
   output logic         hit_xoff,
   output logic [1:0]   seen_q,     // {xon seen, xoff seen}
   output logic [1:0]   recog_evt
);
   assign hit_xon  = rx_valid && (rx_data == xon_char);
   assign hit_xoff = rx_valid && (rx_data == xoff_char);

   logic [1:0] seen_base;
   assign seen_base = stat_rd ? 2'b00 : seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= 2'b00;
         recog_evt <= 2'b00;
      end else begin
         seen_q    <= seen_base | {hit_xon, hit_xoff};
         recog_evt <= {hit_xon & recog_en[1], hit_xoff & recog_en[0]};
      end
   end

   // R1
   xoff_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_xoff |=> seen_q[0]);
   // R1
   xon_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_xon |=> seen_q[1]);
   // R1
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd && seen_q == 2'b11) |=> seen_q == 2'b11);
   // R2
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !rx_valid) |=> seen_q == 2'b00);
   // R4
   evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !recog_en[0] |=> !recog_evt[0]);
endmodule

// File: rtl/xf_tx_flow.sv
`timescale 1ns/1ps
module xf_tx_flow
   import xf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tx_auto,
   input  logic  hit_xon,
   input  logic  hit_xoff,
   input  logic  tx_active,  // shifter busy or being loaded this cycle
   input  logic  stat_rd,
   output flow_e state_q
);
   logic  xoff_go, xon_go;
   flow_e state_nx;

   // a character matching both patterns is treated as XOFF
   assign xoff_go = tx_auto && hit_xoff;
   assign xon_go  = tx_auto && hit_xon && !hit_xoff;

   always_comb begin
      state_nx = state_q;
      if (!tx_auto) begin
         state_nx = FL_RUN;
      end else if (xoff_go) begin
         if (state_q == FL_RUN || state_q == FL_RESUMED)
            state_nx = tx_active ? FL_STOPPING : FL_STOPPED;
      end else if (xon_go) begin
         if (state_q == FL_STOPPING || state_q == FL_STOPPED)
            state_nx = FL_RESUMED;
      end else begin
         unique case (state_q)
            FL_STOPPING: if (!tx_active) state_nx = FL_STOPPED;
            FL_RESUMED:  if (stat_rd)    state_nx = FL_RUN;
            default:     state_nx = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FL_RUN;
      else        state_q <= state_nx;
   end

   // R5
   stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FL_STOPPING && !tx_active && !xon_go) |=> state_q == FL_STOPPED);
   // R5
   xoff_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FL_RUN && xoff_go && tx_active) |=> state_q == FL_STOPPING);
   // R6
   resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FL_STOPPED && xon_go) |=> state_q == FL_RESUMED);
   // R7
   off_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_auto |=> state_q == FL_RUN);
endmodule

// File: rtl/xf_tx_sel.sv
`timescale 1ns/1ps
module xf_tx_sel
   import xf_pkg::*;
#(
   parameter int W         = 8,
   parameter bit INSERT_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_auto,
   input  logic         tx_auto,
   input  logic         cmd_xon,
   input  logic         cmd_xoff,
   input  logic [1:0]   flow,
   input  logic [W-1:0] xon_char,
   input  logic [W-1:0] xoff_char,
   input  logic         fifo_valid,
   input  logic [W-1:0] fifo_data,
   input  logic         sh_busy,
   input  logic         stat_rd,
   output logic         fifo_pop,
   output logic         sh_load,
   output logic [W-1:0] sh_data,
   output logic [1:0]   txc,
   output logic [1:0]   sent_q     // {xoff sent, xon sent}
);
   txc_e       pend_q;
   logic       ins_go, dat_go, flow_open, idle_q;
   logic [1:0] sent_add;

   assign flow_open = (flow == FL_RUN) || (flow == FL_RESUMED);
   assign ins_go    = (pend_q != TC_DATA) && !sh_busy;
   assign dat_go    = !ins_go && !sh_busy && fifo_valid && flow_open;
   assign sh_load   = ins_go || dat_go;
   assign fifo_pop  = dat_go;
   assign sh_data   = !ins_go ? fifo_data :
                      (pend_q == TC_XON) ? xon_char : xoff_char;

   if (INSERT_EN) begin : g_ins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pend_q <= TC_DATA;
         else if (!rx_auto) pend_q <= TC_DATA;
         else if (cmd_xoff) pend_q <= TC_XOFF;
         else if (cmd_xon)  pend_q <= TC_XON;
         else if (ins_go)   pend_q <= TC_DATA;
      end
   end else begin : g_no_ins
      assign pend_q = TC_DATA;
   end

   assign sent_add = !ins_go ? 2'b00 : (pend_q == TC_XON) ? 2'b01 : 2'b10;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sent_q <= 2'b00;
      else if (!rx_auto) sent_q <= 2'b00;
      else               sent_q <= (stat_rd ? 2'b00 : sent_q) | sent_add;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       idle_q <= 1'b0;
      else if (ins_go)                  idle_q <= 1'b1;
      else if (!sh_busy && fifo_valid)  idle_q <= 1'b0;
   end

   always_comb begin
      if (!rx_auto && !tx_auto)    txc = TC_DATA;
      else if (pend_q != TC_DATA)  txc = pend_q;
      else if (idle_q)             txc = TC_WAIT;
      else                         txc = TC_DATA;
   end

   // R8
   no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_load |-> !sh_busy);
   // R8
   ins_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != TC_DATA && !sh_busy) |-> !fifo_pop);
   // R6
   stopped_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow == FL_STOPPED || flow == FL_STOPPING) |-> !fifo_pop);
   // R9
   sent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_auto |=> sent_q == 2'b00);
endmodule

// File: rtl/xonxoff_flow_engine.sv
`timescale 1ns/1ps
module xonxoff_flow_engine
   import xf_pkg::*;
#(
   parameter int W         = 8,
   parameter int N_PAIRS   = 4,
   parameter bit INSERT_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         cfg_xon_char,
   input  logic [W-1:0]         cfg_xoff_char,
   input  logic                 cfg_tx_auto,
   input  logic                 cfg_rx_auto,
   input  logic                 ctl_wr,
   input  logic [2*N_PAIRS-1:0] ctl_wdata,
   output logic [N_PAIRS-1:0]   ctl_en,
   input  logic                 rx_valid,
   input  logic [W-1:0]         rx_data,
   output logic [1:0]           recog_evt,
   input  logic                 cmd_send_xon,
   input  logic                 cmd_send_xoff,
   input  logic                 fifo_valid,
   input  logic [W-1:0]         fifo_data,
   output logic                 fifo_pop,
   input  logic                 sh_busy,
   output logic                 sh_load,
   output logic [W-1:0]         sh_data,
   input  logic                 stat_rd,
   output logic [7:0]           stat_q
);
   if (W < 5 || W > 9) begin : g_bad_w
      $error("xonxoff_flow_engine: W must lie in 5..9");
   end
   if (N_PAIRS < 2 || N_PAIRS > 8) begin : g_bad_pairs
      $error("xonxoff_flow_engine: N_PAIRS must lie in 2..8");
   end

   logic       hit_xon, hit_xoff;
   logic [1:0] seen_q, sent_q, txc;
   flow_e      flow_q;

   xf_ctl_pairs #(.N_PAIRS(N_PAIRS)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .en(ctl_en)
   );

   xf_rx_match #(.W(W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char), .stat_rd(stat_rd),
      .recog_en(ctl_en[1:0]), .hit_xon(hit_xon), .hit_xoff(hit_xoff),
      .seen_q(seen_q), .recog_evt(recog_evt)
   );

   xf_tx_flow u_flow (
      .clk(clk), .rst_n(rst_n), .tx_auto(cfg_tx_auto), .hit_xon(hit_xon),
      .hit_xoff(hit_xoff), .tx_active(sh_busy | sh_load), .stat_rd(stat_rd),
      .state_q(flow_q)
   );

   xf_tx_sel #(.W(W), .INSERT_EN(INSERT_EN)) u_sel (
      .clk(clk), .rst_n(rst_n), .rx_auto(cfg_rx_auto), .tx_auto(cfg_tx_auto),
      .cmd_xon(cmd_send_xon), .cmd_xoff(cmd_send_xoff), .flow(flow_q),
      .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char),
      .fifo_valid(fifo_valid), .fifo_data(fifo_data), .sh_busy(sh_busy),
      .stat_rd(stat_rd), .fifo_pop(fifo_pop), .sh_load(sh_load),
      .sh_data(sh_data), .txc(txc), .sent_q(sent_q)
   );

   assign stat_q = {seen_q, sent_q, flow_q, txc};

   // R10
   txc_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rx_auto && !cfg_tx_auto) |-> stat_q[1:0] == 2'b00);
   // R6
   pop_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (sh_load && sh_data == fifo_data));
endmodule

// File: tb/xonxoff_flow_engine_tb.sv
`timescale 1ns/1ps
module xonxoff_flow_engine_tb_top;
   localparam int          CHAR_CYC = 6;
   localparam logic [7:0]  XON_C    = 8'h11;
   localparam logic [7:0]  XOFF_C   = 8'h13;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [7:0] cfg_xon_char, cfg_xoff_char, ctl_wdata, rx_data, fifo_data, sh_data, stat_q;
   logic       cfg_tx_auto, cfg_rx_auto, ctl_wr, rx_valid, cmd_send_xon, cmd_send_xoff;
   logic       fifo_valid, fifo_pop, sh_busy, sh_load, stat_rd;
   logic [3:0] ctl_en;
   logic [1:0] recog_evt;

   int n_chk = 0, n_bad = 0;
   int fcnt, fhead, ld_n, busy_cnt, push_n;
   logic [7:0] log_mem [0:63];

   always #5 clk = ~clk;

   xonxoff_flow_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
      .cfg_tx_auto(cfg_tx_auto), .cfg_rx_auto(cfg_rx_auto), .ctl_wr(ctl_wr),
      .ctl_wdata(ctl_wdata), .ctl_en(ctl_en), .rx_valid(rx_valid), .rx_data(rx_data),
      .recog_evt(recog_evt), .cmd_send_xon(cmd_send_xon), .cmd_send_xoff(cmd_send_xoff),
      .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
      .sh_busy(sh_busy), .sh_load(sh_load), .sh_data(sh_data), .stat_rd(stat_rd),
      .stat_q(stat_q)
   );

   // shifter and FIFO models
   assign sh_busy    = busy_cnt != 0;
   assign fifo_valid = fcnt != 0;
   assign fifo_data  = 8'h40 + 8'(fhead);

   always @(posedge clk) begin
      if (!rst_n) begin
         busy_cnt <= 0; fcnt <= 0; fhead <= 0; ld_n <= 0;
      end else begin
         busy_cnt <= sh_load ? CHAR_CYC : (busy_cnt != 0 ? busy_cnt - 1 : 0);
         fcnt     <= fcnt + push_n - (fifo_pop ? 1 : 0);
         if (fifo_pop) fhead <= fhead + 1;
         if (sh_load) begin
            log_mem[ld_n[5:0]] <= sh_data;
            ld_n <= ld_n + 1;
         end
      end
   end

   function automatic logic [3:0] ctl_next(logic [3:0] cur, logic wr, logic [7:0] d);
      logic [3:0] r = cur;
      if (wr) for (int k = 0; k < 4; k++) begin
         if (d[2*k+1])    r[k] = 1'b0;
         else if (d[2*k]) r[k] = 1'b1;
      end
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h want %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
      rx_valid = 0; stat_rd = 0; cmd_send_xon = 0; cmd_send_xoff = 0; ctl_wr = 0; push_n = 0;
   endtask

   task automatic rx(logic [7:0] c);
      rx_valid = 1'b1; rx_data = c;
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && (fifo_valid || sh_busy); i++) step();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang want completion");
      finish_run();
   end

   initial begin
      logic [1:0] e_seen, e_evt;
      logic [3:0] e_ctl;
      logic       hx, hf;
      void'($urandom(32'h5eed_0042));
      cfg_xon_char = XON_C; cfg_xoff_char = XOFF_C; cfg_tx_auto = 0; cfg_rx_auto = 0;
      ctl_wr = 0; ctl_wdata = 0; rx_valid = 0; rx_data = 0; cmd_send_xon = 0;
      cmd_send_xoff = 0; stat_rd = 0; push_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R11 reset state
      chk("R11 status", stat_q, 0);
      chk("R11 ctl", ctl_en, 0);
      chk("R11 load/pop/evt", {sh_load, fifo_pop, recog_evt}, 0);

      // random phase, both auto modes off
      e_seen = 0; e_evt = 0; e_ctl = 0;
      for (int it = 0; it < 400; it++) begin
         chk("R1 seen flags", stat_q[7:6], e_seen);
         chk("R4 recog pulse", recog_evt, e_evt);
         chk("R3 ctl pairs", ctl_en, e_ctl);
         chk("R9 sent/flow idle", {stat_q[5:2], sh_load}, 0);
         chk("R10 forced 00", stat_q[1:0], 0);
         if ($urandom % 3 == 0) begin
            case ($urandom % 4)
               0:       rx(XON_C);
               1:       rx(XOFF_C);
               default: rx(8'($urandom));
            endcase
         end
         stat_rd       = ($urandom % 6 == 0);
         cmd_send_xon  = ($urandom % 5 == 0);
         cmd_send_xoff = ($urandom % 5 == 0);
         if ($urandom % 7 == 0) begin ctl_wr = 1; ctl_wdata = 8'($urandom); end
         hx = rx_valid && rx_data == XON_C;
         hf = rx_valid && rx_data == XOFF_C;
         e_evt  = {hx & e_ctl[1], hf & e_ctl[0]};
         e_seen = (stat_rd ? 2'b00 : e_seen) | {hx, hf};
         e_ctl  = ctl_next(e_ctl, ctl_wr, ctl_wdata);
         step();
      end

      // R3 directed pair writes
      ctl_wr = 1; ctl_wdata = 8'h55; step(); chk("R3 all enable", ctl_en, 4'hf);
      ctl_wr = 1; ctl_wdata = 8'h03; step(); chk("R3 both bits disable", ctl_en, 4'he);
      ctl_wr = 1; ctl_wdata = 8'h00; step(); chk("R3 zero no effect", ctl_en, 4'he);
      ctl_wr = 1; ctl_wdata = 8'hc0; step(); chk("R3 watchdog both", ctl_en, 4'h6);

      // R4 gated recognition, R1 flags
      stat_rd = 1; step();
      rx(XOFF_C); step(); chk("R4 xoff gated", recog_evt, 2'b00);
      chk("R1 xoff seen", stat_q[7:6], 2'b01);
      rx(XON_C); step(); chk("R4 xon event", recog_evt, 2'b10);
      chk("R1 both seen", stat_q[7:6], 2'b11);

      // R2 read with concurrent match
      stat_rd = 1; rx(XON_C); step(); chk("R2 match kept", stat_q[7:6], 2'b10);
      stat_rd = 1; step(); chk("R2 clear", stat_q[7:4], 0);

      // R7 flow ignored with auto off
      push_n = 2; step(); step();
      rx(XOFF_C); step(); chk("R7 flow stays", stat_q[3:2], 2'b00);
      drain(); chk("R7 data sent", ld_n, 2); chk("R7 order", log_mem[1], 8'h41);

      // R5/R6 halt while busy
      cfg_tx_auto = 1; push_n = 4; step(); step();
      rx(XOFF_C); step(); chk("R5 halt pending", stat_q[3:2], 2'b01);
      for (int i = 0; i < 20 && sh_busy; i++) step();
      step(); chk("R5 halted", stat_q[3:2], 2'b11);
      repeat (20) step();
      chk("R6 no data while halted", ld_n, 3); chk("R6 fifo held", fifo_valid, 1);
      rx(XON_C); step(); chk("R6 re-enabled", stat_q[3:2], 2'b10);
      drain(); chk("R6 resumed count", ld_n, 6); chk("R6 resumed order", log_mem[5], 8'h45);
      stat_rd = 1; step(); chk("R6 read to normal", stat_q[3:2], 2'b00);

      // R5 xoff while idle
      rx(XOFF_C); step(); chk("R5 idle xoff", stat_q[3:2], 2'b11);

      // R8/R9/R10 insertion while halted
      cfg_rx_auto = 1; push_n = 2; step();
      cmd_send_xoff = 1; step();
      chk("R8 xoff pending", stat_q[1:0], 2'b10);
      chk("R8 load when idle", {sh_load, sh_data}, {1'b1, XOFF_C});
      step();
      chk("R8 xoff loaded", log_mem[6], XOFF_C);
      chk("R9 xoff sent", stat_q[5:4], 2'b10);
      chk("R10 wait state", stat_q[1:0], 2'b01);
      repeat (10) step();
      chk("R10 wait cleared", stat_q[1:0], 2'b00);
      chk("R6 still halted count", ld_n, 7);
      cmd_send_xon = 1; step(); chk("R8 xon pending", stat_q[1:0], 2'b11);
      step();
      chk("R8 xon loaded", log_mem[7], XON_C);
      chk("R9 both sent", stat_q[5:4], 2'b11);
      chk("R8 halt unchanged", stat_q[3:2], 2'b11);

      // R8 insertion waits for shifter, then precedes data
      rx(XON_C); step();
      cmd_send_xoff = 1; step(); chk("R8 no interrupt", sh_load, 0);
      for (int i = 0; i < 20 && sh_busy; i++) step();
      step(); chk("R8 insert before data", log_mem[8], XOFF_C);
      drain(); chk("R8 data after insert", log_mem[9], 8'h46); chk("R8 count", ld_n, 11);

      // R2 read concurrent with insertion
      stat_rd = 1; step();
      cmd_send_xon = 1; step();
      stat_rd = 1; step(); chk("R2 insert kept", stat_q[5:4], 2'b01);

      // R9 off, R10 forced, R7 cleared
      drain();
      cfg_rx_auto = 0; step(); chk("R9 cleared", stat_q[5:4], 2'b00);
      cmd_send_xon = 1; step();
      chk("R9 cmd ignored", {sh_load, stat_q[1:0]}, {1'b0, 2'b01});
      cfg_tx_auto = 0; step();
      chk("R10 forced", stat_q[1:0], 2'b00);
      chk("R7 flow normal", stat_q[3:2], 2'b00);

      finish_run();
   end
endmodule